// File: doc/BRIEF.md
# Serial Port Interrupt Status Logic

This block produces the interrupt conditions of a FIFO-based synchronous serial port. From the two FIFO occupancy counts, a receive-frame-complete pulse, a receive-FIFO-full flag, a bit-period tick and an idle indication, it derives four raw interrupt sources. These are a transmit low-watermark level, a receive high-watermark level, a receive timeout and a sticky receive overrun.

A mask register gates each raw source into a masked status vector. A single combined interrupt line is the OR of the masked bits. A write-1-to-clear strobe removes the two event-type sources. The FIFOs, the shift register and the bus decode are outside the block. The surrounding logic supplies decoded write strobes and reads the status vectors directly.

Top module: `spi_irq_status`

## Requirements
- R1: Status bit 3 (transmit) is 1 in the cycle after any clock edge at which `tx_level` is 4 or less. Otherwise it is 0. No enable input qualifies it.
- R2: Status bit 2 (receive) is 1 in the cycle after any clock edge at which `rx_level` is 4 or more. Otherwise it is 0.
- R3: Status bit 1 (timeout) sets after 32 `bit_tick` edges with `link_idle` high and `rx_level` non-zero, with no frame completion in between. It is visible after the edge of the 32nd tick. A low `link_idle`, an empty receive FIFO or `rx_frame_done` restarts the count.
- R4: Status bit 1 clears on an edge where `rx_level` is 0 or `rx_frame_done` is high. It also clears on an edge where `clr_wr` is high with `clr_wdata[1]`=1. A new firing in the same edge wins over the clear.
- R5: Status bit 0 (overrun) sets on any edge where `rx_frame_done` and `rx_full` are both high. This set wins over a clear written in the same cycle.
- R6: Status bit 0 stays set until an edge with `clr_wr` high and `clr_wdata[0]`=1. A clear write with a bit at 0 leaves the matching source unchanged.
- R7: `mask_q` loads `mask_wdata` on an edge with `mask_wr` high and otherwise holds. Its bit positions match the status bits.
- R8: `masked_stat[i]` equals `raw_stat[i] & mask_q[i]` for every bit.
- R9: `irq` is high exactly when any bit of `masked_stat` is high.
- R10: While `rst_n` is low, `raw_stat`, `mask_q`, `masked_stat` and `irq` are all 0.
- R11: After a timeout is cleared by a write, it does not fire again while idleness continues. A restart of the count is needed first; the counter does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_level | input | 4 | Valid entries in the transmit FIFO |
| rx_level | input | 4 | Valid entries in the receive FIFO |
| rx_frame_done | input | 1 | One-cycle pulse when a receive frame completes |
| rx_full | input | 1 | Receive FIFO is full |
| bit_tick | input | 1 | One-cycle pulse per serial bit period |
| link_idle | input | 1 | Serial link is idle |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 4 | Mask write data |
| clr_wr | input | 1 | Clear register write strobe |
| clr_wdata | input | 4 | Clear write data, 1 clears (bits 1 and 0 act) |
| raw_stat | output | 4 | Raw status {tx, rx, timeout, overrun} |
| mask_q | output | 4 | Current mask |
| masked_stat | output | 4 | Raw status AND mask |
| irq | output | 1 | OR of masked status |

## Verification
Both FIFO levels are swept over 0 to 8 so that the two watermark bits separate the "4 or less" and "4 or more" boundaries from their neighbours. The timeout is driven with sparse bit ticks. Each run of ticks is broken once by a busy link, once by a frame completion, and once by a write clear followed by more idle ticks. These runs tell an exact 32-period count from an off-by-one count, from a wrapping count, and from a count that ignores restarts. Overrun is probed with a clear of zeros, a real clear, and a clear that coincides with a new overrun. This separates sticky set-priority behaviour from level behaviour. Several mask patterns, including complementary ones, show that each masked bit follows only its own raw bit.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int NUM_SRC = 4;
  localparam int IDX_TX  = 3;
  localparam int IDX_RX  = 2;
  localparam int IDX_TO  = 1;
  localparam int IDX_OVR = 0;
endpackage

// File: rtl/irq_level_flags.sv
module irq_level_flags #(
  parameter int LVL_W    = 4,
  parameter int TX_WATER = 4,
  parameter int RX_WATER = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  output logic             tx_low,
  output logic             rx_high
);
  localparam logic [LVL_W-1:0] TX_LIM = LVL_W'(TX_WATER);
  localparam logic [LVL_W-1:0] RX_LIM = LVL_W'(RX_WATER);

  logic tx_low_d, rx_high_d;

  always_comb begin
    tx_low_d  = (tx_level <= TX_LIM);
    rx_high_d = (rx_level >= RX_LIM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_low  <= 1'b0;
      rx_high <= 1'b0;
    end else begin
      tx_low  <= tx_low_d;
      rx_high <= rx_high_d;
    end
  end

  // R1
  tx_water_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (tx_low == ($past(tx_level) <= TX_LIM)));
  // R2
  rx_water_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (rx_high == ($past(rx_level) >= RX_LIM)));
endmodule

// File: rtl/irq_rx_timeout.sv
module irq_rx_timeout #(
  parameter int LVL_W     = 4,
  parameter int IDLE_BITS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_frame_done,
  input  logic             bit_tick,
  input  logic             link_idle,
  input  logic             clr_req,
  output logic             timeout
);
  localparam int CNT_W = $clog2(IDLE_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(IDLE_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IDLE_BITS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             to_d;
  logic             rx_empty, restart, count_en, fire, drop;

  always_comb begin
    rx_empty = (rx_level == '0);
    restart  = rx_frame_done | rx_empty | ~link_idle;
    count_en = ~restart & bit_tick & (cnt_q != CNT_SAT);
    fire     = count_en & (cnt_q == CNT_LAST);
    drop     = rx_frame_done | rx_empty | clr_req;
    cnt_d    = cnt_q;
    if (restart)       cnt_d = '0;
    else if (count_en) cnt_d = cnt_q + 1'b1;
    to_d = timeout;
    if (fire)      to_d = 1'b1;
    else if (drop) to_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      timeout <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      timeout <= to_d;
    end
  end

  // R3
  to_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> $past(bit_tick && link_idle && !rx_frame_done));
  // R4
  to_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(timeout) |-> $past(rx_frame_done || rx_level == '0 || clr_req));
  // R11
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_SAT);
endmodule

// File: rtl/irq_sticky_flag.sv
module irq_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag
);
  logic flag_d;

  always_comb begin
    flag_d = flag;
    if (set_evt)      flag_d = 1'b1;
    else if (clr_req) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_d;
  end

  // R5
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(set_evt) |-> flag);
  // R6
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(clr_req));
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int TX_WATER   = 4,
  parameter int RX_WATER   = 4,
  parameter int IDLE_BITS  = 32,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LVL_W-1:0]   tx_level,
  input  logic [LVL_W-1:0]   rx_level,
  input  logic               rx_frame_done,
  input  logic               rx_full,
  input  logic               bit_tick,
  input  logic               link_idle,
  input  logic               mask_wr,
  input  logic [NUM_SRC-1:0] mask_wdata,
  input  logic               clr_wr,
  input  logic [NUM_SRC-1:0] clr_wdata,
  output logic [NUM_SRC-1:0] raw_stat,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] masked_stat,
  output logic               irq
);
  logic tx_low, rx_high, timeout, overrun;
  logic to_clr, ovr_clr, ovr_set;
  logic [NUM_SRC-1:0] mask_d;

  assign to_clr  = clr_wr & clr_wdata[IDX_TO];
  assign ovr_clr = clr_wr & clr_wdata[IDX_OVR];
  assign ovr_set = rx_frame_done & rx_full;

  irq_level_flags #(.LVL_W(LVL_W), .TX_WATER(TX_WATER), .RX_WATER(RX_WATER)) u_levels (
    .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
    .tx_low(tx_low), .rx_high(rx_high));

  irq_rx_timeout #(.LVL_W(LVL_W), .IDLE_BITS(IDLE_BITS)) u_timeout (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .rx_frame_done(rx_frame_done),
    .bit_tick(bit_tick), .link_idle(link_idle), .clr_req(to_clr), .timeout(timeout));

  irq_sticky_flag u_overrun (
    .clk(clk), .rst_n(rst_n), .set_evt(ovr_set), .clr_req(ovr_clr), .flag(overrun));

  always_comb begin
    mask_d = mask_q;
    if (mask_wr) mask_d = mask_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  always_comb begin
    raw_stat          = '0;
    raw_stat[IDX_TX]  = tx_low;
    raw_stat[IDX_RX]  = rx_high;
    raw_stat[IDX_TO]  = timeout;
    raw_stat[IDX_OVR] = overrun;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_gate
    assign masked_stat[i] = raw_stat[i] & mask_q[i];
  end

  assign irq = |masked_stat;

  // R7
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(mask_wr) |-> (mask_q == $past(mask_wdata)));
  // R7
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(mask_wr) |-> $stable(mask_q));
endmodule

// File: tb/tb_spi_irq_status.sv
module tb_spi_irq_status;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] tx_level, rx_level;
  logic       rx_frame_done, rx_full, bit_tick, link_idle;
  logic       mask_wr, clr_wr;
  logic [3:0] mask_wdata, clr_wdata;
  logic [3:0] raw_stat, mask_q, masked_stat;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;

  spi_irq_status dut (
    .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
    .rx_frame_done(rx_frame_done), .rx_full(rx_full), .bit_tick(bit_tick),
    .link_idle(link_idle), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .clr_wr(clr_wr), .clr_wdata(clr_wdata), .raw_stat(raw_stat),
    .mask_q(mask_q), .masked_stat(masked_stat), .irq(irq));

  always #4 clk = ~clk;

  // behavioural reference
  bit m_tx, m_rx, m_to, m_ovr;
  bit [3:0] m_mask;
  int idle_run;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tx = 0; m_rx = 0; m_to = 0; m_ovr = 0; m_mask = 0; idle_run = 0;
    end else begin
      bit brk, hit;
      m_tx = (int'(tx_level) <= 4);
      m_rx = (int'(rx_level) >= 4);
      if (mask_wr) m_mask = mask_wdata;
      if (rx_frame_done && rx_full) m_ovr = 1;
      else if (clr_wr && clr_wdata[0]) m_ovr = 0;
      brk = rx_frame_done || rx_level == 0 || !link_idle;
      hit = !brk && bit_tick && idle_run == 31;
      if (hit) m_to = 1;
      else if (rx_frame_done || rx_level == 0 || (clr_wr && clr_wdata[1])) m_to = 0;
      if (brk) idle_run = 0;
      else if (bit_tick && idle_run < 32) idle_run++;
    end
  end

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [3:0] er;
    er = {m_tx, m_rx, m_to, m_ovr};
    chk("R1 transmit bit3", {3'b0, raw_stat[3]}, {3'b0, er[3]});
    chk("R2 receive bit2", {3'b0, raw_stat[2]}, {3'b0, er[2]});
    chk("R3 R4 R11 timeout bit1", {3'b0, raw_stat[1]}, {3'b0, er[1]});
    chk("R5 R6 overrun bit0", {3'b0, raw_stat[0]}, {3'b0, er[0]});
    chk("R7 mask", mask_q, m_mask);
    chk("R8 masked", masked_stat, er & m_mask);
    chk("R9 irq", {3'b0, irq}, {3'b0, |(er & m_mask)});
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      compare();
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1; step(1);
      bit_tick = 0; step(1);
    end
  endtask

  task automatic wclr(logic [3:0] v);
    clr_wr = 1; clr_wdata = v; step(1);
    clr_wr = 0; clr_wdata = 0;
  endtask

  task automatic wmask(logic [3:0] v);
    mask_wr = 1; mask_wdata = v; step(1);
    mask_wr = 0; mask_wdata = 0;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; tx_level = 0; rx_level = 0; rx_frame_done = 0; rx_full = 0;
    bit_tick = 0; link_idle = 0; mask_wr = 0; mask_wdata = 0;
    clr_wr = 0; clr_wdata = 0;
    repeat (3) @(negedge clk);
    // R10: everything zero under reset
    chk("R10 reset raw", raw_stat, 4'b0);
    chk("R10 reset mask", mask_q, 4'b0);
    chk("R10 reset irq", {masked_stat[2:0], irq}, 4'b0);
    rst_n = 1;
    step(2);

    wmask(4'b1111);
    // R1 R2 level sweeps
    for (int t = 0; t <= 8; t++) begin
      tx_level = 4'(t); rx_level = 4'(8 - t); step(2);
    end
    wmask(4'b1010);
    for (int t = 8; t >= 0; t--) begin
      tx_level = 4'(t); rx_level = 4'(t); step(1);
    end
    wmask(4'b0101);
    tx_level = 8; rx_level = 2; step(2);

    // R3 timeout after 32 idle ticks, R11 no refire after clear
    wmask(4'b0010);
    link_idle = 1;
    ticks(31); step(3);
    ticks(1); step(2);
    wclr(4'b0010);
    ticks(40);
    // R3 restart by busy link mid-count
    link_idle = 0; step(1); link_idle = 1;
    ticks(20);
    link_idle = 0; step(1); link_idle = 1;
    ticks(31); ticks(1); step(1);
    // R4 cleared by frame completion
    rx_frame_done = 1; step(1); rx_frame_done = 0;
    ticks(32);
    // R4 cleared by FIFO emptied
    rx_level = 0; step(2); rx_level = 3;
    ticks(32);
    // R4 clear with zero bits has no effect, then timeout bit write clear
    wclr(4'b1101); step(1);
    wclr(4'b0010); step(1);

    // R5 R6 overrun
    wmask(4'b0001);
    rx_full = 1; rx_frame_done = 1; step(1); rx_frame_done = 0;
    step(3);
    wclr(4'b1110); step(2);
    wclr(4'b0001); step(2);
    rx_frame_done = 1; clr_wr = 1; clr_wdata = 4'b0001; step(1);
    rx_frame_done = 0; clr_wr = 0; clr_wdata = 0; step(2);
    rx_full = 0; rx_frame_done = 1; step(1); rx_frame_done = 0;
    wclr(4'b1111); step(2);
    wmask(4'b0000); step(2);

    summary();
    $finish;
  end
endmodule